// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Datapath

This block turns the raw per-sample decisions of a pipelined converter into one calibrated output code. The converter has thirteen 1.5-bit stages, each reporting a ternary decision, and a closing 1-bit comparator. The datapath rebuilds the sampled input from the back of the pipe toward the front. Each step scales the previous estimate by a residue-gain coefficient and adds the stage decision weighted by a DAC-gain coefficient. The two front stages also pass the incoming estimate through a cubic inverse term first. A stored zero-input offset is then removed, and the result is scaled and clamped to a signed 10-bit code.

The seven back-end 1.5-bit stages use one shared gain coefficient and a fixed, ideal DAC weight. The back-end estimate is cut to five bits of resolution before the six front stages refine it. The datapath takes one sample per clock and delivers each result after a fixed delay. Coefficients come from an external register file and are expected to stay constant while samples are in flight.

Top module: `adc_recon`

## Requirements
- R1: Stage decisions are 2-bit two's complement codes: 01 is +1, 00 is 0, 11 is -1. Stage s sits at bits [2s-1:2s-2] of `stage_dec`, for s = 1 to 13. For stages 3 to 6: est_s = floor(g_s·x / 2^10) + D_s·dac_s, where x = est_{s+1}. g_s is the signed 12-bit field [12s-1:12s-12] of `stage_gain`, and dac_s is the signed 18-bit field [18s-1:18s-18] of `stage_dac`.
- R2: For stages 1 and 2, x is first replaced by x + c, with c = floor(a_s·t³ / 2^14). Here t is bits [13:8] of est_{s+1}, read as a signed 6-bit value. a_s is the signed 4-bit field [4s-1:4s-4] of `cube_coef`.
- R3: The last stage gives est_14 = +4096 when `last_bit` is 1 and -4096 when it is 0. Stages 7 to 13 use est_s = floor(tail_gain·x / 2^10) + D_s·4096, with one shared 12-bit signed `tail_gain`.
- R4: After it is formed, est_7 is floored to a multiple of 512, which leaves five bits of resolution over its ±8192 span.
- R5: The output is floor((est_1 − zero_offset) / 16), with `zero_offset` read as signed 18 bits.
- R6: A result above 511 is given as 511, and a result below -512 is given as -512. `out_code` is signed two's complement.
- R7: A sample is accepted on every clock where `in_valid` is high. Its result appears with `out_valid` high exactly 15 clock edges after the edge that captured it, counting that edge, and in the same order as the samples.
- R8: During reset, `out_valid` and `out_code` are 0. While `out_valid` is low, `out_code` keeps its last value.
- R9: Decision code 10 counts as a 0 decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample decisions are present |
| stage_dec | input | 26 | Ternary decisions of stages 1 to 13 |
| last_bit | input | 1 | Decision of the final 1-bit stage |
| stage_gain | input | 72 | Residue-gain coefficients, stages 1 to 6 (Q1.10) |
| stage_dac | input | 108 | DAC-gain coefficients, stages 1 to 6 |
| cube_coef | input | 8 | Cubic coefficients for stages 1 and 2 |
| tail_gain | input | 12 | Shared back-end residue gain (Q1.10) |
| zero_offset | input | 18 | Stored zero-input offset |
| out_valid | output | 1 | Corrected code is valid |
| out_code | output | 10 | Corrected signed output code |

## Verification
The bench targets the places where an arithmetic slip changes only a few codes. The first is the sign and truncation of the cubic input slice: a wrong slice or unsigned read moves results only when the cubic coefficients are non-zero. The others are the floor of the back-end estimate to 512, the floor rather than round of negative products, and the odd decision code 10. Offsets large enough to push the result past both ends show whether clamping happens, and whether it happens before or after the shift; a design that wrapped would show the code jumping to the opposite extreme. Back-to-back samples with idle gaps show whether decisions stay aligned with their own sample and whether the output holds between results.

// File: rtl/adc_recon.sv
module adc_recon #(
  parameter int EW   = 18,
  parameter int CW   = 12,
  parameter int CF   = 10,
  parameter int REFB = 12,
  parameter int OW   = 10,
  parameter int BEW  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [25:0]          stage_dec,
  input  logic                 last_bit,
  input  logic [6*CW-1:0]      stage_gain,
  input  logic [6*EW-1:0]      stage_dac,
  input  logic [7:0]           cube_coef,
  input  logic [CW-1:0]        tail_gain,
  input  logic [EW-1:0]        zero_offset,
  output logic                 out_valid,
  output logic [OW-1:0]        out_code
);
  localparam int NST = 13;
  localparam int DW  = 2 * NST;
  localparam int REF = 1 << REFB;
  localparam int OS  = REFB + 2 - OW;
  localparam int TRB = REFB + 2 - BEW;
  localparam int TS  = REFB + 2 - 6;
  localparam int CSH = 14;

  logic signed [EW-1:0] est_q [0:NST];
  logic signed [EW-1:0] est_d [1:NST];
  logic [DW-1:0]        dec_q [0:NST-1];
  logic                 vld_q [0:NST];

  for (genvar k = 1; k <= NST; k++) begin : g_step
    localparam int S = NST + 1 - k;
    logic signed [EW-1:0]    xin, dv, dterm, nxt;
    logic signed [CW-1:0]    g;
    logic signed [EW+CW-1:0] prod;
    logic [1:0]              dc;

    assign dc = dec_q[k-1][DW-1:DW-2];

    if (S <= 2) begin : g_cubic
      logic signed [5:0]  t;
      logic signed [3:0]  a;
      logic signed [21:0] cube;
      logic signed [21:0] csh;
      assign t    = est_q[k-1][TS+5:TS];
      assign a    = cube_coef[4*S-1 -: 4];
      assign cube = a * t * t * t;
      assign csh  = cube >>> CSH;
      assign xin  = est_q[k-1] + $signed({{(EW-6){csh[5]}}, csh[5:0]});
    end else begin : g_plain
      assign xin = est_q[k-1];
    end

    if (S >= 7) begin : g_tail
      assign g  = tail_gain;
      assign dv = EW'(REF);
    end else begin : g_front
      assign g  = stage_gain[CW*S-1 -: CW];
      assign dv = stage_dac[EW*S-1 -: EW];
    end

    assign prod  = xin * g;
    assign dterm = (dc == 2'b01) ? dv : (dc == 2'b11) ? -dv : '0;
    assign nxt   = EW'(prod >>> CF) + dterm;

    if (S == 7) begin : g_trunc
      assign est_d[k] = nxt & ~EW'((1 << TRB) - 1);
    end else begin : g_keep
      assign est_d[k] = nxt;
    end
  end

  always_ff @(posedge clk) begin
    est_q[0] <= last_bit ? EW'(REF) : -EW'(REF);
    dec_q[0] <= stage_dec;
    for (int k = 1; k <= NST; k++) est_q[k] <= est_d[k];
    for (int k = 1; k < NST; k++)  dec_q[k] <= dec_q[k-1] << 2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= NST; k++) vld_q[k] <= 1'b0;
    end else begin
      vld_q[0] <= in_valid;
      for (int k = 1; k <= NST; k++) vld_q[k] <= vld_q[k-1];
    end
  end

  logic signed [EW-1:0] est_front;
  logic                 vld_front;
  logic signed [EW:0]   diff;
  logic signed [EW-OS:0] scl;
  logic                 fits;
  logic [OW-1:0]        sat;

  assign est_front = est_q[NST];
  assign vld_front = vld_q[NST];
  assign diff = $signed({est_front[EW-1], est_front}) - $signed({zero_offset[EW-1], zero_offset});
  assign scl  = diff >>> OS;
  assign fits = (scl[EW-OS:OW-1] == '0) || (scl[EW-OS:OW-1] == '1);
  assign sat  = fits ? scl[OW-1:0]
              : (scl[EW-OS] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= vld_front;
      if (vld_front) out_code <= sat;
    end
  end
endmodule

// File: rtl/adc_recon_chk.sv
module adc_recon_chk #(
  parameter int EW   = 18,
  parameter int OW   = 10,
  parameter int REFB = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [OW-1:0]        out_code,
  input logic                 vld_front,
  input logic signed [EW-1:0] est_front,
  input logic [EW-1:0]        zero_offset
);
  localparam int OS   = REFB + 2 - OW;
  localparam int MAXC = (1 << (OW-1)) - 1;
  localparam int MINC = -(1 << (OW-1));
  localparam int HI   = (MAXC + 1) << OS;
  localparam int LO   = MINC * (1 << OS);

  int dchk;
  assign dchk = int'($signed(est_front)) - int'($signed(zero_offset));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 15));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_code));

  p_clamp_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_front && dchk >= HI) |=> (int'($signed(out_code)) == MAXC));

  p_clamp_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_front && dchk < LO) |=> (int'($signed(out_code)) == MINC));
endmodule

bind adc_recon adc_recon_chk #(.EW(EW), .OW(OW), .REFB(REFB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_code(out_code), .vld_front(vld_front), .est_front(est_front),
  .zero_offset(zero_offset)
);

// File: tb/sim_adc_recon.sv
`timescale 1ns/1ps
module sim_adc_recon;
  localparam int REF = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [25:0] stage_dec = '0;
  logic last_bit = 1'b0;
  logic [71:0] stage_gain = '0;
  logic [107:0] stage_dac = '0;
  logic [7:0] cube_coef = '0;
  logic [11:0] tail_gain = '0;
  logic [17:0] zero_offset = '0;
  logic out_valid;
  logic [9:0] out_code;

  adc_recon u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stage_dec(stage_dec),
    .last_bit(last_bit), .stage_gain(stage_gain), .stage_dac(stage_dac),
    .cube_coef(cube_coef), .tail_gain(tail_gain), .zero_offset(zero_offset),
    .out_valid(out_valid), .out_code(out_code));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0, nsent = 0, rx = 0, n_hi = 0, n_lo = 0;
  int exp_q [0:4095];
  int issue [0:4095];
  string tagq [0:4095];
  string cur_tag = "R1";
  int g [1:6];
  int dv [1:6];
  int a3 [1:2];
  int gb = 512, off = 0;
  int unsigned st = 32'h1234_5678;
  logic [9:0] last_code = '0;
  bit seen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int model(input logic [25:0] d, input logic lb);
    longint e, x, c, t, gg, dd;
    int dc;
    e = lb ? REF : -REF;
    for (int s = 13; s >= 1; s--) begin
      x = e;
      if (s <= 2) begin
        t = (x >>> 8) & 63;
        if (t >= 32) t -= 64;
        c = (longint'(a3[s]) * t * t * t) >>> 14;
        x += c;
      end
      gg = (s >= 7) ? gb : g[s];
      dd = (s >= 7) ? REF : dv[s];
      dc = (d[2*s-2 +: 2] == 2'b01) ? 1 : (d[2*s-2 +: 2] == 2'b11) ? -1 : 0;
      e = ((gg * x) >>> 10) + dc * dd;
      if (s == 7) e = e & ~longint'(511);
    end
    e = (e - off) >>> 4;
    if (e > 511) e = 511;
    if (e < -512) e = -512;
    return int'(e);
  endfunction

  task automatic apply_cfg();
    for (int s = 1; s <= 6; s++) begin
      stage_gain[12*s-1 -: 12] = g[s][11:0];
      stage_dac[18*s-1 -: 18]  = dv[s][17:0];
    end
    cube_coef  = {a3[2][3:0], a3[1][3:0]};
    tail_gain  = gb[11:0];
    zero_offset = off[17:0];
  endtask

  task automatic ideal();
    for (int s = 1; s <= 6; s++) begin g[s] = 512; dv[s] = REF; end
    a3[1] = 0; a3[2] = 0; gb = 512; off = 0;
  endtask

  task automatic rnd(output logic [1:0] code, input bit bad);
    st = st * 32'd1103515245 + 32'd12345;
    case (st[17:16])
      2'd0: code = 2'b00;
      2'd1: code = 2'b01;
      2'd2: code = 2'b11;
      default: code = bad ? 2'b10 : 2'b01;
    endcase
  endtask

  task automatic send(input logic [25:0] d, input logic lb);
    @(negedge clk);
    stage_dec = d; last_bit = lb; in_valid = 1'b1;
    exp_q[nsent] = model(d, lb);
    issue[nsent] = cyc;
    tagq[nsent] = cur_tag;
    nsent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(18);
    chk(rx == nsent, "R7", rx, nsent);
  endtask

  task automatic rand_burst(input int n, input bit bad, input int gap_every);
    logic [25:0] d;
    logic [1:0] cd;
    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < 13; s++) begin rnd(cd, bad); d[2*s +: 2] = cd; end
      send(d, st[20]);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(2);
    end
    drain();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (rx < nsent) begin
          chk(int'($signed(out_code)) == exp_q[rx], tagq[rx], int'($signed(out_code)), exp_q[rx]);
          chk(cyc - issue[rx] == 15, "R7", cyc - issue[rx], 15);
          if (int'($signed(out_code)) == 511) n_hi++;
          if (int'($signed(out_code)) == -512) n_lo++;
        end else begin
          chk(1'b0, "R7", rx, nsent);
        end
        rx++;
        last_code = out_code;
        seen = 1;
      end else if (seen) begin
        chk(out_code == last_code, "R8", int'($signed(out_code)), int'($signed(last_code)));
      end
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", rx, nsent);
    finish_up();
  end

  initial begin
    logic [25:0] d;
    logic [1:0] cd;
    logic [1:0] map3 [0:2];
    map3[0] = 2'b00; map3[1] = 2'b01; map3[2] = 2'b11;
    ideal();
    apply_cfg();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
    chk(out_code == '0, "R8", int'($signed(out_code)), 0);
    rst_n = 1'b1;

    // R4: ideal coefficients, exhaustive over the first three stages
    cur_tag = "R4";
    for (int a = 0; a < 27; a++)
      for (int lb = 0; lb < 2; lb++)
        for (int r = 0; r < 4; r++) begin
          for (int s = 3; s < 13; s++) begin rnd(cd, 1'b0); d[2*s +: 2] = cd; end
          d[1:0] = map3[a % 3];
          d[3:2] = map3[(a / 3) % 3];
          d[5:4] = map3[a / 9];
          send(d, lb[0]);
        end
    drain();

    // R1: uneven front gains and DAC weights, with idle gaps
    cur_tag = "R1";
    g[1] = 470; g[2] = 545; g[3] = 498; g[4] = 530; g[5] = 461; g[6] = 560;
    dv[1] = 3950; dv[2] = 4210; dv[3] = 4050; dv[4] = 4290; dv[5] = 3901; dv[6] = 4100;
    apply_cfg();
    rand_burst(200, 1'b0, 37);

    // R3: shared back-end gain off nominal
    cur_tag = "R3";
    ideal(); gb = 481; apply_cfg();
    rand_burst(150, 1'b0, 0);
    gb = 540; apply_cfg();
    rand_burst(150, 1'b0, 0);

    // R2: every cubic coefficient value on both front stages
    cur_tag = "R2";
    ideal(); gb = 470;
    for (int v = -8; v <= 7; v++) begin
      a3[1] = v; a3[2] = -1 - v;
      apply_cfg();
      rand_burst(16, 1'b0, 0);
    end

    // R9: odd decision code mixed in
    cur_tag = "R9";
    ideal(); g[2] = 520; dv[3] = 4000; apply_cfg();
    rand_burst(150, 1'b1, 0);
    for (int s = 1; s <= 13; s++) begin
      d = 26'h0;
      d[2*s-2 +: 2] = 2'b10;
      send(d, s[0]);
    end
    drain();

    // R5: moderate offsets of both signs
    cur_tag = "R5";
    ideal(); off = 1234; apply_cfg();
    rand_burst(100, 1'b0, 0);
    off = -777; apply_cfg();
    rand_burst(100, 1'b0, 0);

    // R6: offsets that push the result past both ends
    cur_tag = "R6";
    n_hi = 0; n_lo = 0;
    ideal(); off = 6000; apply_cfg();
    rand_burst(120, 1'b0, 0);
    off = -6000; apply_cfg();
    rand_burst(120, 1'b0, 0);
    chk(n_hi > 0, "R6", n_hi, 1);
    chk(n_lo > 0, "R6", n_lo, 1);

    idle(5);
    finish_up();
  end
endmodule